// File: doc/BRIEF.md
# Out-of-Place Page Update Controller for Erase-Block Storage

This block fronts a small internal page store that follows flash rules. The store is split into physical erase blocks of equal size. A page in it can be programmed only once between erases of its block. A client reads and writes whole pages by logical page address, using a start/busy/done handshake. Each logical block is held in one physical block through a translation map, and the physical blocks not currently mapped form a spare pool.

A write to a page that is still erased is programmed where it sits. A write to a page that already holds data is never done in place. The controller first takes the least-worn spare block that is still serviceable and erases it, which is a long fixed-length wait. It then programs the new page into that block and copies every other programmed page across from the old block. Finally it remaps the logical block to the new block and returns the old block to the spare pool. Every erase bumps a per-block wear counter. A block whose counter reaches the wear limit is never taken from the pool again. If no serviceable spare exists, the write is abandoned and the stored data stays as it was.

Top module: `pgx_flash_xlate`

## Requirements
- R1: After reset the controller is idle: busy is 0 and done is 0. Reading any logical page that has never been written returns all ones.
- R2: No physical page is programmed a second time before its block has been erased. A read always returns the data most recently written to that logical page.
- R3: A write to a logical page that is still erased in its mapped block is programmed in place. done rises one cycle after start is taken.
- R4: A write to an already programmed page moves the logical block to a freshly erased block. All other written pages of that logical block are preserved. done rises 2 + ERASE_CYCLES + PAGES cycles after start is taken.
- R5: The spare block taken for a move is the serviceable free block with the lowest erase count. On a tie, the lowest physical index wins.
- R6: A block whose erase count has reached WEAR_LIMIT is never taken. If no serviceable spare exists, a write to a programmed page leaves all data unchanged and done rises one cycle after start.
- R7: A read returns the page data on rdata when done is high, one cycle after start. busy is high from the cycle after start is taken until done. done is high for exactly one cycle.
- R8: A start that arrives while busy is high is ignored and does not change any stored page.
- R9: After a move, the physical block that was left returns to the spare pool and can be taken by later moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| wr | input | 1 | 1 = write page, 0 = read page |
| laddr | input | log2(NUM_LBLK)+log2(PAGES) | Logical page address: upper bits select the logical block, lower bits the page |
| wdata | input | DATA_W | Page data to write |
| rdata | output | DATA_W | Page data returned by a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with 2 logical blocks, 4 physical blocks, 4 pages per block, 8-bit pages, a 6-cycle erase and a wear limit of 5. With a wear limit this small, the spare pool runs out of serviceable blocks within a few hundred operations. That brings wear-ordered selection, block reuse, retirement and abandoned writes all within reach. The page space is only eight pages, so every page is read back after each of several full write sweeps in different address orders. The bench also checks the exact latency of in-place, moved and abandoned writes, and a start raised during a move.

// File: rtl/pgx_pkg.sv
// Shared types for the page translation controller.
package pgx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_ERASE,
        S_PROG,
        S_COPY
    } pgx_state_e;
endpackage

// File: rtl/pgx_page_store.sv
// Page array with a programmed flag per page.
// Erase wipes one whole block to ones in a single cycle (the caller models the
// erase time). Program writes one page. Assumes erase and program never coincide
// and PAGES is a power of two.
module pgx_page_store #(
    parameter int NUM_PBLK = 4,
    parameter int PAGES    = 4,
    parameter int DATA_W   = 8,
    localparam int NPG  = NUM_PBLK * PAGES,
    localparam int PA_W = $clog2(NPG),
    localparam int PB_W = $clog2(NUM_PBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_en,
    input  logic [PB_W-1:0]   erase_blk,
    input  logic              prog_en,
    input  logic [PA_W-1:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [PA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_used
);
    logic [DATA_W-1:0] mem [NPG];
    logic [NPG-1:0]    used;

    // Array update: reset or erase to ones, program one page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPG; p++) mem[p] <= '1;
            used <= '0;
        end else begin
            for (int p = 0; p < NPG; p++) begin
                if (erase_en && (p / PAGES) == int'(erase_blk)) begin
                    mem[p]  <= '1;
                    used[p] <= 1'b0;
                end
            end
            if (prog_en) begin
                mem[prog_addr]  <= prog_data;
                used[prog_addr] <= 1'b1;
            end
        end
    end

    // Asynchronous read port.
    always_comb begin
        rd_data = mem[rd_addr];
        rd_used = used[rd_addr];
    end

    // R2
    no_reprogram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !used[prog_addr]);

    // R2
    no_mixed_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en));
endmodule

// File: rtl/pgx_block_pool.sv
// Spare-block pool with per-block erase counters.
// Picks the free block with the lowest count below WEAR_LIMIT, lowest index on
// ties. take marks a block erased and in use; give returns a block to the pool.
// Assumes the first NUM_LBLK physical blocks start mapped.
module pgx_block_pool #(
    parameter int NUM_PBLK   = 4,
    parameter int NUM_LBLK   = 2,
    parameter int WEAR_LIMIT = 1000,
    localparam int PB_W  = $clog2(NUM_PBLK),
    localparam int CNT_W = $clog2(WEAR_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_en,
    input  logic [PB_W-1:0] take_blk,
    input  logic            give_en,
    input  logic [PB_W-1:0] give_blk,
    output logic            pick_ok,
    output logic [PB_W-1:0] pick_blk
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WEAR_LIMIT);

    logic [CNT_W-1:0]    cnt [NUM_PBLK];
    logic [NUM_PBLK-1:0] free_q;
    logic [CNT_W-1:0]    best_c;

    // Wear counters and free flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_PBLK; b++) begin
                cnt[b]    <= '0;
                free_q[b] <= (b >= NUM_LBLK);
            end
        end else begin
            if (take_en) begin
                free_q[take_blk] <= 1'b0;
                if (cnt[take_blk] != LIMIT) cnt[take_blk] <= cnt[take_blk] + 1'b1;
            end
            if (give_en) free_q[give_blk] <= 1'b1;
        end
    end

    // Lowest-wear selection; strict compare keeps the lowest index on ties.
    always_comb begin
        pick_ok  = 1'b0;
        pick_blk = '0;
        best_c   = '0;
        for (int b = 0; b < NUM_PBLK; b++) begin
            if (free_q[b] && cnt[b] < LIMIT && (!pick_ok || cnt[b] < best_c)) begin
                pick_ok  = 1'b1;
                pick_blk = PB_W'(b);
                best_c   = cnt[b];
            end
        end
    end

    // R6
    take_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> (free_q[take_blk] && cnt[take_blk] < LIMIT));

    // R9
    give_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        give_en |-> !free_q[give_blk]);

    // R5: no serviceable free block is less worn than the pick.
    always @(posedge clk) begin
        if (rst_n && pick_ok) begin
            for (int b = 0; b < NUM_PBLK; b++) begin
                if (free_q[b] && cnt[b] < LIMIT)
                    pick_min_chk: assert (cnt[b] >= cnt[pick_blk]);
            end
        end
    end
endmodule

// File: rtl/pgx_flash_xlate.sv
// Logical page controller over an erase-before-program page store.
// Reads and in-place writes take one cycle. A rewrite erases a fresh block
// (ERASE_CYCLES wait), programs the page, copies the other programmed pages,
// then remaps. Assumes NUM_LBLK < NUM_PBLK and power-of-two sizes, each >= 2.
module pgx_flash_xlate
    import pgx_pkg::*;
#(
    parameter int NUM_LBLK     = 2,
    parameter int NUM_PBLK     = 4,
    parameter int PAGES        = 4,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 6,
    parameter int WEAR_LIMIT   = 1000,
    localparam int LB_W = $clog2(NUM_LBLK),
    localparam int PB_W = $clog2(NUM_PBLK),
    localparam int PG_W = $clog2(PAGES),
    localparam int LA_W = LB_W + PG_W,
    localparam int PA_W = PB_W + PG_W,
    localparam int EC_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [LA_W-1:0]   laddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done
);
    localparam logic [PG_W-1:0] LAST_PG = PG_W'(PAGES - 1);

    pgx_state_e        state;
    logic              wr_q;
    logic [LB_W-1:0]   lblk_q;
    logic [PG_W-1:0]   pg_q;
    logic [DATA_W-1:0] data_q;
    logic [PB_W-1:0]   map_q [NUM_LBLK];
    logic [PB_W-1:0]   new_q;
    logic [EC_W-1:0]   ecnt;
    logic [PG_W-1:0]   cpi;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    logic [PB_W-1:0]   cur_pblk;
    logic [PA_W-1:0]   rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_used;
    logic              prog_en;
    logic [PA_W-1:0]   prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic              erase_en;
    logic              give_en;
    logic              pick_ok;
    logic [PB_W-1:0]   pick_blk;

    // Store access steering per state.
    always_comb begin
        cur_pblk  = map_q[lblk_q];
        rd_addr   = (state == S_COPY) ? {cur_pblk, cpi} : {cur_pblk, pg_q};
        prog_en   = 1'b0;
        prog_addr = {cur_pblk, pg_q};
        prog_data = data_q;
        case (state)
            S_CHK:  prog_en = wr_q && !rd_used;
            S_PROG: begin
                prog_en   = 1'b1;
                prog_addr = {new_q, pg_q};
            end
            S_COPY: begin
                prog_en   = (cpi != pg_q) && rd_used;
                prog_addr = {new_q, cpi};
                prog_data = rd_data;
            end
            default: ;
        endcase
        erase_en = (state == S_ERASE) && (ecnt == '0);
        give_en  = (state == S_COPY) && (cpi == LAST_PG);
    end

    pgx_page_store #(
        .NUM_PBLK (NUM_PBLK),
        .PAGES    (PAGES),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  (erase_en),
        .erase_blk (new_q),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_used   (rd_used)
    );

    pgx_block_pool #(
        .NUM_PBLK   (NUM_PBLK),
        .NUM_LBLK   (NUM_LBLK),
        .WEAR_LIMIT (WEAR_LIMIT)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_en  (erase_en),
        .take_blk (new_q),
        .give_en  (give_en),
        .give_blk (cur_pblk),
        .pick_ok  (pick_ok),
        .pick_blk (pick_blk)
    );

    // Operation sequencer, map update and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wr_q    <= 1'b0;
            lblk_q  <= '0;
            pg_q    <= '0;
            data_q  <= '0;
            new_q   <= '0;
            ecnt    <= '0;
            cpi     <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            for (int i = 0; i < NUM_LBLK; i++) map_q[i] <= PB_W'(i);
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    wr_q   <= wr;
                    lblk_q <= laddr[LA_W-1:PG_W];
                    pg_q   <= laddr[PG_W-1:0];
                    data_q <= wdata;
                    state  <= S_CHK;
                end
                S_CHK: begin
                    if (!wr_q) begin
                        rdata_q <= rd_data;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end else if (rd_used && pick_ok) begin
                        new_q <= pick_blk;
                        ecnt  <= EC_W'(ERASE_CYCLES - 1);
                        state <= S_ERASE;
                    end else begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                S_ERASE: begin
                    if (ecnt == '0) state <= S_PROG;
                    else ecnt <= ecnt - 1'b1;
                end
                S_PROG: begin
                    cpi   <= '0;
                    state <= S_COPY;
                end
                S_COPY: begin
                    cpi <= cpi + 1'b1;
                    if (cpi == LAST_PG) begin
                        map_q[lblk_q] <= new_q;
                        done_q        <= 1'b1;
                        state         <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy  = (state != S_IDLE);
    assign done  = done_q;
    assign rdata = rdata_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lblk_q) && $stable(pg_q) && $stable(wr_q) && $stable(data_q)));

    // R3
    inplace_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHK && wr_q && !rd_used) |=> (done && !busy));

    // R4
    erase_blk_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE) |-> (new_q != cur_pblk));
endmodule

// File: tb/pgx_flash_xlate_bench.sv
module pgx_flash_xlate_bench;
    localparam int NLB = 2, NPB = 4, PG = 4, DW = 8, EC = 6, WL = 5;
    localparam int NLP = NLB * PG;
    localparam int SWAP_LAT = 2 + EC + PG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    laddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          busy, done;

    int total = 0;
    int bad = 0;

    // Reference state derived from the requirements.
    logic [DW-1:0] exp_d [NLP];
    bit            exp_u [NLP];
    int            mmap  [NLB];
    int            cnt   [NPB];
    bit            fr    [NPB];

    always #10 clk = ~clk;

    pgx_flash_xlate #(
        .NUM_LBLK(NLB), .NUM_PBLK(NPB), .PAGES(PG), .DATA_W(DW),
        .ERASE_CYCLES(EC), .WEAR_LIMIT(WL)
    ) u_pgx_flash_xlate (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .laddr(laddr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_pick();
        int best = -1;
        for (int b = 0; b < NPB; b++)
            if (fr[b] && cnt[b] < WL && (best < 0 || cnt[b] < cnt[best])) best = b;
        return best;
    endfunction

    // Returns the expected latency and the tag of the rule that decides it.
    task automatic model_write(int a, logic [DW-1:0] d, output int lat, output string tag);
        int lb = a / PG;
        int p;
        if (!exp_u[a]) begin
            exp_d[a] = d; exp_u[a] = 1; lat = 1; tag = "R3";
        end else begin
            p = model_pick();
            if (p < 0) begin
                lat = 1; tag = "R6";
            end else begin
                cnt[p]++; fr[p] = 0; fr[mmap[lb]] = 1; mmap[lb] = p;
                exp_d[a] = d; lat = SWAP_LAT; tag = "R4 R5 R9";
            end
        end
    endtask

    task automatic op(bit w, int a, logic [DW-1:0] d, int inj,
                      output int lat, output logic [DW-1:0] q);
        @(negedge clk);
        start = 1'b1; wr = w; laddr = 3'(a); wdata = d;
        @(negedge clk);
        if (inj < 0) start = 1'b0;
        else begin laddr = 3'(inj); wdata = 8'h33; end
        chk(busy === 1'b1, "R7", "busy after start", int'(busy), 1);
        lat = 0;
        while (done !== 1'b1 && lat < 1000) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(busy === 1'b0, "R7", "busy at done", int'(busy), 0);
        q = rdata;
        @(negedge clk);
        chk(done === 1'b0, "R7", "done width", int'(done), 0);
    endtask

    task automatic read_all(string tag);
        int lat;
        logic [DW-1:0] q;
        for (int a = 0; a < NLP; a++) begin
            op(1'b0, a, '0, -1, lat, q);
            chk(lat == 1, "R7", "read latency", lat, 1);
            chk(q === exp_d[a], tag, $sformatf("data page %0d", a), int'(q), int'(exp_d[a]));
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, elat;
        string tag;
        logic [DW-1:0] q, d;
        for (int a = 0; a < NLP; a++) begin exp_d[a] = '1; exp_u[a] = 0; end
        for (int b = 0; b < NPB; b++) begin cnt[b] = 0; fr[b] = (b >= NLB); end
        for (int l = 0; l < NLB; l++) mmap[l] = l;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
        read_all("R1");

        // R3: first write goes in place
        model_write(0, 8'h10, elat, tag);
        op(1'b1, 0, 8'h10, -1, lat, q);
        chk(lat == elat, "R3", "in-place latency", lat, elat);
        // R8: rewrite with a second start raised while busy toward page 5
        model_write(0, 8'h20, elat, tag);
        op(1'b1, 0, 8'h20, 5, lat, q);
        chk(lat == elat, "R4", "move latency", lat, elat);
        op(1'b0, 5, '0, -1, lat, q);
        chk(q === 8'hFF, "R8", "page 5 after ignored start", int'(q), 255);
        op(1'b0, 0, '0, -1, lat, q);
        chk(q === 8'h20, "R4", "page 0 after move", int'(q), 32);

        // Full sweeps in several address orders, until the pool wears out.
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < NLP; i++) begin
                int a = (i * 3 + p) % NLP;
                d = 8'((a * 37 + p * 11 + 5) & 255);
                model_write(a, d, elat, tag);
                op(1'b1, a, d, -1, lat, q);
                chk(lat == elat, tag, $sformatf("write latency page %0d", a), lat, elat);
            end
            read_all("R2 R4 R5 R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule